// File: doc/BRIEF.md
# ALU with Two-Bit Condition Register

This block is the combinational arithmetic and logic stage of a small 16-bit processor. It takes a 4-bit operation code, a 3-bit shift selector, the destination register number, an addressing-mode hint and the two operands. Operand A is the destination register's contents and operand B is the already-resolved second operand. From these it produces the result word, a write enable for that result, a new condition code and a write enable for the condition code.

All flag information is folded into one 2-bit condition code, so a result is reported as zero, positive, negative or overflowed. Overflow outranks the other three encodings. The compare operation only refreshes the condition code. The byte-move operation has two uses. With a memory operand it copies one byte of the operand word. With a register operand it exchanges the two halves of that register. When the destination register number is zero and the operand comes from memory, the add code becomes an increment of the operand and the subtract code becomes a negation of it.

Register file writes, store routing, branch decisions and I/O are handled by the surrounding datapath, not by this block.

Top module: `alu_cr_core`

## Requirements
- R1: Code 0010 gives A+B, 0011 gives A-B, 0100 gives A AND B, 0101 gives A OR B and 0110 gives A XOR B. Each of these asserts both `res_we` and `cc_we`.
- R2: Code 1111 gives the bitwise inverse of B and asserts both write enables.
- R3: Code 1101 forms A-B only to set the condition code. `cc_we` is 1 and `res_we` is 0.
- R4: Code 1100 with `reg_mode`=0 keeps the upper byte of A. Its lower byte becomes B's upper byte when `byte_lo`=0, or B's lower byte when `byte_lo`=1.
- R5: Code 1100 with `reg_mode`=1 gives B with its two bytes exchanged.
- R6: Code 0010 with `dst_reg`=0 and `reg_mode`=0 gives B+1. With `reg_mode`=1 it stays a plain A+B.
- R7: Code 0011 with `dst_reg`=0 and `reg_mode`=0 gives 0-B.
- R8: Code 0111 shifts A by one place. `shift_sel` 000 is an arithmetic left shift, 001 an arithmetic right shift (sign kept), 010 a logical left shift and 111 a right rotate. Any other selector asserts neither write enable.
- R9: `cc_out` is 0 for a zero result, 1 for a positive result, 2 for a result whose top bit is set, and 3 for overflow.
- R10: Signed two's-complement overflow on add, subtract, increment, negate or compare forces `cc_out`=3, even when the wrapped result is zero or negative.
- R11: AND, OR, XOR, inverse, byte moves, the arithmetic right shift, the logical left shift and the rotate never give `cc_out`=3.
- R12: An arithmetic left shift gives `cc_out`=3 when bits 15 and 14 of A differ.
- R13: Codes 0000, 0001, 1000, 1001, 1010, 1011 and 1110 assert neither write enable. In that case, and whenever `cc_we` is 0, `cc_out` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation code |
| shift_sel | input | 3 | Shift kind for code 0111 |
| dst_reg | input | 4 | Destination register number |
| reg_mode | input | 1 | 1 when the second operand is a register |
| byte_lo | input | 1 | Byte selector: 0 upper byte, 1 lower byte |
| opa | input | 16 | Operand A (destination contents) |
| opb | input | 16 | Operand B (resolved operand) |
| result | output | 16 | Result word |
| cc_out | output | 2 | New condition code |
| res_we | output | 1 | Result is to be written |
| cc_we | output | 1 | Condition code is to be written |

## Verification
The bench builds the block at its default 16-bit width. At that width the signed limits 0x7FFF and 0x8000 and the 0xFFFF wraparound can be reached by directed vectors. Those vectors probe where overflow must outrank the zero and negative codes, the increment and negate edge values, each shift selector, and the byte selector in both states. A long run of random codes, which includes the unsupported ones, is then compared every clock against a model that works on signed integers.

// File: rtl/alu_cr_pkg.sv
package alu_cr_pkg;

    localparam int OPC_W = 4;
    localparam int SHF_W = 3;
    localparam int CC_W  = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD   = 4'b0010,
        OPC_SUB   = 4'b0011,
        OPC_AND   = 4'b0100,
        OPC_OR    = 4'b0101,
        OPC_XOR   = 4'b0110,
        OPC_SHIFT = 4'b0111,
        OPC_BYTE  = 4'b1100,
        OPC_CMP   = 4'b1101,
        OPC_INV   = 4'b1111
    } opc_e;

    typedef enum logic [SHF_W-1:0] {
        SH_ASL = 3'b000,
        SH_ASR = 3'b001,
        SH_LSL = 3'b010,
        SH_ROR = 3'b111
    } shf_e;

    typedef enum logic [CC_W-1:0] {
        CC_ZERO = 2'd0,
        CC_POS  = 2'd1,
        CC_NEG  = 2'd2,
        CC_OVF  = 2'd3
    } cc_e;

    typedef enum logic [1:0] {
        AR_ADD,
        AR_SUB,
        AR_INC,
        AR_NEG
    } arith_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_ARITH,
        SRC_LOGIC,
        SRC_BYTE,
        SRC_SHIFT
    } src_e;

    typedef struct packed {
        logic res_we;
        logic cc_we;
        src_e src;
    } ctl_t;

    function automatic logic opc_known(input logic [OPC_W-1:0] c);
        return (c == OPC_ADD) || (c == OPC_SUB) || (c == OPC_AND) ||
               (c == OPC_OR)  || (c == OPC_XOR) || (c == OPC_SHIFT) ||
               (c == OPC_BYTE) || (c == OPC_CMP) || (c == OPC_INV);
    endfunction

    function automatic logic shf_known(input logic [SHF_W-1:0] s);
        return (s == SH_ASL) || (s == SH_ASR) || (s == SH_LSL) || (s == SH_ROR);
    endfunction

endpackage

// File: rtl/alu_cr_arith.sv
module alu_cr_arith
    import alu_cr_pkg::*;
#(
    parameter int W = 16
) (
    input  arith_e         kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   sum,
    output logic           ovf
);
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;

    always_comb begin
        case (kind)
            AR_SUB:  begin x = a;  y = ~b; cin = 1'b1; end
            AR_INC:  begin x = b;  y = '0; cin = 1'b1; end
            AR_NEG:  begin x = '0; y = ~b; cin = 1'b1; end
            default: begin x = a;  y = b;  cin = 1'b0; end
        endcase
        sum = x + y + {{(W-1){1'b0}}, cin};
        ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_cr_bitwise.sv
module alu_cr_bitwise
    import alu_cr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OPC_W-1:0] op_code,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);
    always_comb begin
        case (op_code)
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_XOR: y = a ^ b;
            OPC_INV: y = ~b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_cr_bytemove.sv
module alu_cr_bytemove #(
    parameter int W = 16
) (
    input  logic         reg_mode,
    input  logic         byte_lo,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int HW = W / 2;

    logic [HW-1:0] picked;

    always_comb begin
        picked = byte_lo ? b[HW-1:0] : b[W-1:HW];
        if (reg_mode)
            y = {b[HW-1:0], b[W-1:HW]};
        else
            y = {a[W-1:HW], picked};
    end
endmodule

// File: rtl/alu_cr_shifter.sv
module alu_cr_shifter
    import alu_cr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [SHF_W-1:0] sel,
    input  logic [W-1:0]     a,
    output logic [W-1:0]     y,
    output logic             ovf,
    output logic             hit
);
    always_comb begin
        y   = '0;
        ovf = 1'b0;
        hit = 1'b1;
        case (sel)
            SH_ASL: begin
                y   = {a[W-2:0], 1'b0};
                ovf = a[W-1] ^ a[W-2];
            end
            SH_ASR:  y = {a[W-1], a[W-1:1]};
            SH_LSL:  y = {a[W-2:0], 1'b0};
            SH_ROR:  y = {a[0], a[W-1:1]};
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_cr_ccgen.sv
module alu_cr_ccgen
    import alu_cr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic         ovf,
    output cc_e          cc
);
    always_comb begin
        if (ovf)
            cc = CC_OVF;
        else if (value == '0)
            cc = CC_ZERO;
        else if (value[W-1])
            cc = CC_NEG;
        else
            cc = CC_POS;
    end
endmodule

// File: rtl/alu_cr_core.sv
module alu_cr_core
    import alu_cr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int REG_W = 4
) (
    input  logic [OPC_W-1:0] op_code,
    input  logic [SHF_W-1:0] shift_sel,
    input  logic [REG_W-1:0] dst_reg,
    input  logic             reg_mode,
    input  logic             byte_lo,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic [CC_W-1:0]  cc_out,
    output logic             res_we,
    output logic             cc_we
);
    logic             unary_mem;
    arith_e           ar_kind;
    ctl_t             ctl;
    logic [WIDTH-1:0] ar_sum, lg_val, by_val, sh_val;
    logic             ar_ovf, sh_ovf, sh_hit;
    logic [WIDTH-1:0] sel_val;
    logic             sel_ovf;
    cc_e              cc_new;

    assign unary_mem = !reg_mode && (dst_reg == '0);

    always_comb begin
        ctl     = '{res_we: 1'b0, cc_we: 1'b0, src: SRC_NONE};
        ar_kind = AR_ADD;
        case (op_code)
            OPC_ADD: begin
                ar_kind = unary_mem ? AR_INC : AR_ADD;
                ctl     = '{res_we: 1'b1, cc_we: 1'b1, src: SRC_ARITH};
            end
            OPC_SUB: begin
                ar_kind = unary_mem ? AR_NEG : AR_SUB;
                ctl     = '{res_we: 1'b1, cc_we: 1'b1, src: SRC_ARITH};
            end
            OPC_CMP: begin
                ar_kind = AR_SUB;
                ctl     = '{res_we: 1'b0, cc_we: 1'b1, src: SRC_ARITH};
            end
            OPC_AND, OPC_OR, OPC_XOR, OPC_INV:
                ctl = '{res_we: 1'b1, cc_we: 1'b1, src: SRC_LOGIC};
            OPC_BYTE:
                ctl = '{res_we: 1'b1, cc_we: 1'b1, src: SRC_BYTE};
            OPC_SHIFT:
                if (sh_hit)
                    ctl = '{res_we: 1'b1, cc_we: 1'b1, src: SRC_SHIFT};
            default: ;
        endcase
    end

    alu_cr_arith #(.W(WIDTH)) u_arith (
        .kind (ar_kind),
        .a    (opa),
        .b    (opb),
        .sum  (ar_sum),
        .ovf  (ar_ovf)
    );

    alu_cr_bitwise #(.W(WIDTH)) u_bitwise (
        .op_code (op_code),
        .a       (opa),
        .b       (opb),
        .y       (lg_val)
    );

    alu_cr_bytemove #(.W(WIDTH)) u_bytemove (
        .reg_mode (reg_mode),
        .byte_lo  (byte_lo),
        .a        (opa),
        .b        (opb),
        .y        (by_val)
    );

    alu_cr_shifter #(.W(WIDTH)) u_shifter (
        .sel (shift_sel),
        .a   (opa),
        .y   (sh_val),
        .ovf (sh_ovf),
        .hit (sh_hit)
    );

    always_comb begin
        case (ctl.src)
            SRC_ARITH: begin sel_val = ar_sum; sel_ovf = ar_ovf; end
            SRC_LOGIC: begin sel_val = lg_val; sel_ovf = 1'b0;   end
            SRC_BYTE:  begin sel_val = by_val; sel_ovf = 1'b0;   end
            SRC_SHIFT: begin sel_val = sh_val; sel_ovf = sh_ovf; end
            default:   begin sel_val = '0;     sel_ovf = 1'b0;   end
        endcase
    end

    alu_cr_ccgen #(.W(WIDTH)) u_ccgen (
        .value (sel_val),
        .ovf   (sel_ovf),
        .cc    (cc_new)
    );

    assign result = ctl.res_we ? sel_val : '0;
    assign cc_out = ctl.cc_we ? cc_new : CC_ZERO;
    assign res_we = ctl.res_we;
    assign cc_we  = ctl.cc_we;

endmodule

// File: rtl/alu_cr_checks.sv
module alu_cr_checks
    import alu_cr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int REG_W = 4
) (
    input logic [OPC_W-1:0] op_code,
    input logic [SHF_W-1:0] shift_sel,
    input logic [REG_W-1:0] dst_reg,
    input logic             reg_mode,
    input logic             byte_lo,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] result,
    input logic [CC_W-1:0]  cc_out,
    input logic             res_we,
    input logic             cc_we
);
    localparam int HW = WIDTH / 2;

    logic known;
    logic logic_like;

    always_comb begin
        known = !$isunknown({op_code, shift_sel, dst_reg, reg_mode, byte_lo,
                             opa, opb, result, cc_out, res_we, cc_we});
        logic_like = (op_code == OPC_AND) || (op_code == OPC_OR) ||
                     (op_code == OPC_XOR) || (op_code == OPC_INV) ||
                     (op_code == OPC_BYTE);
        if (known) begin
            // R11: logic and byte operations never signal overflow
            if (logic_like)
                assert_logic_no_ovf_R11: assert (cc_out != CC_OVF)
                    else $error("logic op reported overflow");
            // R3: compare refreshes only the condition code
            if (op_code == OPC_CMP)
                assert_cmp_cc_only_R3: assert (cc_we && !res_we)
                    else $error("compare write enables wrong");
            // R9: non-overflow code agrees with the written result
            if (res_we && cc_out != CC_OVF)
                assert_cc_matches_R9: assert (((result == '0) == (cc_out == CC_ZERO)) &&
                                              (result[WIDTH-1] == (cc_out == CC_NEG)))
                    else $error("condition code disagrees with result");
            // R4: memory byte move keeps the upper byte of A
            if (op_code == OPC_BYTE && !reg_mode)
                assert_byte_keep_high_R4: assert (result[WIDTH-1:HW] == opa[WIDTH-1:HW])
                    else $error("byte move disturbed upper byte");
            // R13: unsupported codes stay idle
            if (!opc_known(op_code))
                assert_unknown_idle_R13: assert (!res_we && !cc_we && cc_out == CC_ZERO)
                    else $error("unsupported code produced a write");
            // R8: unlisted shift selectors stay idle
            if (op_code == OPC_SHIFT && !shf_known(shift_sel))
                assert_bad_shift_idle_R8: assert (!res_we && !cc_we)
                    else $error("unlisted shift produced a write");
            // R1: any result write comes with a condition write
            if (res_we)
                assert_we_pair_R1: assert (cc_we)
                    else $error("result write without condition write");
        end
    end
endmodule

bind alu_cr_core alu_cr_checks #(.WIDTH(WIDTH), .REG_W(REG_W)) u_checks (
    .op_code   (op_code),
    .shift_sel (shift_sel),
    .dst_reg   (dst_reg),
    .reg_mode  (reg_mode),
    .byte_lo   (byte_lo),
    .opa       (opa),
    .opb       (opb),
    .result    (result),
    .cc_out    (cc_out),
    .res_we    (res_we),
    .cc_we     (cc_we)
);

// File: tb/alu_cr_core_test.sv
module alu_cr_core_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_code = 4'b0000;
    logic [2:0]   shift_sel = 3'b000;
    logic [3:0]   dst_reg = 4'd1;
    logic         reg_mode = 1'b0;
    logic         byte_lo = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic [1:0]   cc_out;
    logic         res_we;
    logic         cc_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_cr_core #(.WIDTH(W), .REG_W(4)) uut (
        .op_code   (op_code),
        .shift_sel (shift_sel),
        .dst_reg   (dst_reg),
        .reg_mode  (reg_mode),
        .byte_lo   (byte_lo),
        .opa       (opa),
        .opb       (opb),
        .result    (result),
        .cc_out    (cc_out),
        .res_we    (res_we),
        .cc_we     (cc_we)
    );

    function automatic int sval(input logic [15:0] v);
        return v[15] ? int'(v) - 65536 : int'(v);
    endfunction

    function automatic logic [1:0] code_of(input int r, input bit ov);
        logic [15:0] t;
        t = r[15:0];
        if (ov) return 2'd3;
        if (t == 16'h0) return 2'd0;
        if (t[15]) return 2'd2;
        return 2'd1;
    endfunction

    task automatic model(output logic [15:0] er, output logic [1:0] ec,
                         output bit erw, output bit ecw, output string tag);
        int av, bv, r;
        bit ov;
        av = sval(opa); bv = sval(opb); r = 0; ov = 0;
        erw = 1; ecw = 1; tag = "R13";
        case (op_code)
            4'b0010: begin
                if (!reg_mode && dst_reg == 0) begin r = bv + 1; tag = "R6"; end
                else begin r = av + bv; tag = "R1"; end
                ov = (r > 32767) || (r < -32768);
            end
            4'b0011: begin
                if (!reg_mode && dst_reg == 0) begin r = 0 - bv; tag = "R7"; end
                else begin r = av - bv; tag = "R1"; end
                ov = (r > 32767) || (r < -32768);
            end
            4'b1101: begin
                r = av - bv; tag = "R3"; erw = 0;
                ov = (r > 32767) || (r < -32768);
            end
            4'b0100: begin r = int'(opa & opb); tag = "R1"; end
            4'b0101: begin r = int'(opa | opb); tag = "R1"; end
            4'b0110: begin r = int'(opa ^ opb); tag = "R1"; end
            4'b1111: begin r = int'(~opb);      tag = "R2"; end
            4'b1100: begin
                if (reg_mode) begin r = (int'(opb) % 256) * 256 + int'(opb) / 256; tag = "R5"; end
                else begin
                    r = (int'(opa) / 256) * 256 +
                        (byte_lo ? int'(opb) % 256 : int'(opb) / 256);
                    tag = "R4";
                end
            end
            4'b0111: begin
                tag = "R8";
                case (shift_sel)
                    3'b000: begin r = (int'(opa) * 2) % 65536; ov = (opa[15] != opa[14]); tag = "R12"; end
                    3'b001: r = (av < 0) ? (av - 1) / 2 : av / 2;
                    3'b010: r = (int'(opa) * 2) % 65536;
                    3'b111: r = int'(opa) / 2 + (opa[0] ? 32768 : 0);
                    default: begin erw = 0; ecw = 0; end
                endcase
            end
            default: begin erw = 0; ecw = 0; end
        endcase
        er = erw ? r[15:0] : 16'h0;
        ec = ecw ? code_of(r, ov) : 2'd0;
    endtask

    task automatic compare(input string note);
        logic [15:0] er;
        logic [1:0]  ec;
        bit          erw, ecw;
        string       tag;
        model(er, ec, erw, ecw, tag);
        checks++;
        if (result !== er || cc_out !== ec || res_we !== erw || cc_we !== ecw) begin
            fails++;
            $display("FAIL %s %s: op=%b sh=%b a=%h b=%h got res=%h cc=%0d rwe=%b cwe=%b expected res=%h cc=%0d rwe=%b cwe=%b",
                     tag, note, op_code, shift_sel, opa, opb, result, cc_out, res_we, cc_we,
                     er, ec, erw, ecw);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [2:0] sh, input logic [3:0] dr,
                         input logic rm, input logic bl, input logic [15:0] a,
                         input logic [15:0] b, input string note);
        @(posedge clk);
        #1;
        op_code = op; shift_sel = sh; dst_reg = dr; reg_mode = rm; byte_lo = bl;
        opa = a; opb = b;
        @(negedge clk);
        compare(note);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R13 idle during reset");
        rst = 1'b0;

        // R1 basic ops
        drive(4'b0010, 3'd0, 4'd1, 1, 0, 16'h0001, 16'h0002, "R1 add");
        drive(4'b0011, 3'd0, 4'd1, 1, 0, 16'h0005, 16'h0007, "R1 sub negative");
        drive(4'b0100, 3'd0, 4'd1, 1, 0, 16'hF0F0, 16'h3C3C, "R1 and");
        drive(4'b0101, 3'd0, 4'd1, 1, 0, 16'h00F0, 16'h000F, "R1 or");
        drive(4'b0110, 3'd0, 4'd1, 1, 0, 16'hAAAA, 16'hAAAA, "R1 xor zero R9");
        // R2
        drive(4'b1111, 3'd0, 4'd1, 1, 0, 16'h1234, 16'h00FF, "R2 invert");
        // R9/R10 edges
        drive(4'b0010, 3'd0, 4'd1, 1, 0, 16'hFFFF, 16'h0001, "R9 wrap to zero");
        drive(4'b0010, 3'd0, 4'd1, 1, 0, 16'h7FFF, 16'h0001, "R10 add overflow");
        drive(4'b0010, 3'd0, 4'd1, 1, 0, 16'h8000, 16'h8000, "R10 overflow to zero");
        drive(4'b0011, 3'd0, 4'd1, 1, 0, 16'h8000, 16'h0001, "R10 sub overflow");
        // R3 compare
        drive(4'b1101, 3'd0, 4'd1, 1, 0, 16'h0005, 16'h0005, "R3 equal");
        drive(4'b1101, 3'd0, 4'd1, 1, 0, 16'h8000, 16'h0001, "R3 R10 overflow");
        // R4/R5 byte moves
        drive(4'b1100, 3'd0, 4'd1, 0, 0, 16'h1234, 16'hABCD, "R4 upper byte");
        drive(4'b1100, 3'd0, 4'd1, 0, 1, 16'h1234, 16'hABCD, "R4 lower byte");
        drive(4'b1100, 3'd0, 4'd1, 1, 0, 16'h1234, 16'hABCD, "R5 swap");
        // R6/R7 unary
        drive(4'b0010, 3'd0, 4'd0, 0, 0, 16'h1111, 16'h7FFF, "R6 R10 inc overflow");
        drive(4'b0010, 3'd0, 4'd0, 0, 0, 16'h1111, 16'hFFFF, "R6 inc to zero");
        drive(4'b0010, 3'd0, 4'd0, 1, 0, 16'h1111, 16'h0002, "R6 reg mode stays add");
        drive(4'b0011, 3'd0, 4'd0, 0, 0, 16'h1111, 16'h0001, "R7 negate");
        drive(4'b0011, 3'd0, 4'd0, 0, 0, 16'h1111, 16'h8000, "R7 R10 negate overflow");
        drive(4'b0011, 3'd0, 4'd0, 0, 0, 16'h1111, 16'h0000, "R7 negate zero");
        // R8/R11/R12 shifts
        drive(4'b0111, 3'b000, 4'd1, 0, 0, 16'h4000, 16'h0, "R12 asl overflow");
        drive(4'b0111, 3'b000, 4'd1, 0, 0, 16'hC001, 16'h0, "R12 asl no overflow");
        drive(4'b0111, 3'b001, 4'd1, 0, 0, 16'h8002, 16'h0, "R8 asr");
        drive(4'b0111, 3'b010, 4'd1, 0, 0, 16'h4000, 16'h0, "R8 R11 lsl no overflow");
        drive(4'b0111, 3'b111, 4'd1, 0, 0, 16'h0001, 16'h0, "R8 ror");
        drive(4'b0111, 3'b011, 4'd1, 0, 0, 16'h1234, 16'h0, "R8 unlisted selector");
        // R13
        drive(4'b0001, 3'd0, 4'd1, 0, 0, 16'h1234, 16'h5678, "R13 code 0001");
        drive(4'b1110, 3'd0, 4'd1, 0, 0, 16'h1234, 16'h5678, "R13 code 1110");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            drive(rnd[3:0], rnd[6:4], (rnd[7] ? 4'd0 : rnd[11:8]), rnd[12], rnd[13],
                  16'($urandom), 16'($urandom), "random");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule